// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Load Cache

This block is the lookup path of a first-level set-associative cache whose sets are chosen by address bits that lie inside the page offset. Those bits are identical before and after translation. The tag and data arrays can therefore be read in the same cycle that a load's virtual address is presented, while the translation unit converts the virtual page number. One cycle later the physical page number comes back. It is compared against the tags already read out, and the hitting way's word is returned in that same cycle.

Each stored tag is a full physical page number. The set count is tied to the page size, so a way can never be larger than a page, and the only way to gain capacity is to add ways. By default the cache has 8 KB pages, 32-byte lines, 256 sets and 2 ways, for 16 KB in total. On a miss the block stalls. It asks the next level for the physical line and writes the returned line into a victim way. The victim is an invalid way if the set has one; otherwise it is the way named by a per-set replacement pointer. A translation fault turns the access into a faulting miss that returns no data and starts no refill.

Top module: `vipt_l1`

## Requirements
- R1: After reset every line is invalid, req_ready is 1, refill_req is 0 and rsp_valid is 0, so the first access to any set misses.
- R2: The set is chosen by req_vaddr[12:5], which lies inside the page offset. Two virtual addresses with different page numbers and the same low 13 bits, translated to the same physical page, hit the same line.
- R3: A hit requires a valid way whose stored physical page number equals xlat_ppn. The same virtual address translated to a different physical page misses.
- R4: When a request is accepted (req_valid and req_ready), xlat_req is 1 and xlat_vpn equals req_vaddr[31:13] in that cycle. Exactly one cycle later rsp_valid is 1, and the result is formed from xlat_ppn and xlat_fault sampled in that response cycle. rsp_valid is 0 in any cycle that does not follow an accepted request.
- R5: On a hit, rsp_data is 32-bit word number req_vaddr[4:2] of the line, where word 0 occupies line bits [31:0]. rsp_data is 0 whenever rsp_hit is 0.
- R6: A miss without a fault raises refill_req from the next cycle. refill_paddr is {xlat_ppn, index, 5'b0} and is held steady until refill_valid. While refill_req is high, req_ready and xlat_req stay 0.
- R7: In the cycle refill_valid is seen, refill_line is written with its tag into the lowest-numbered invalid way of the set, or into the pointer-selected way if all ways are valid. That way becomes valid, refill_req drops and req_ready returns, and a repeated access then hits.
- R8: For 2 ways the per-set pointer names the least recently used way. A hit or a refill moves the pointer away from the way it used, so the way that was not touched most recently is the one replaced.
- R9: When xlat_fault is 1 in the response cycle, rsp_fault and rsp_miss are 1, rsp_hit is 0, rsp_data is 0 and no refill is requested.
- R10: A hit does not stall: a new request can be accepted in the same cycle that a hitting response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_vaddr | input | 32 | Virtual byte address of the load |
| req_ready | output | 1 | Request can be accepted this cycle |
| xlat_req | output | 1 | Translation request, same cycle as acceptance |
| xlat_vpn | output | 19 | Virtual page number to translate |
| xlat_ppn | input | 19 | Physical page number, valid one cycle after xlat_req |
| xlat_fault | input | 1 | Translation fault, valid with xlat_ppn |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Load hit |
| rsp_miss | output | 1 | Load did not hit (includes faults) |
| rsp_fault | output | 1 | Translation fault on this load |
| rsp_data | output | 32 | Loaded word, zero unless hit |
| refill_req | output | 1 | Line fill requested from next level |
| refill_paddr | output | 32 | Physical line address of the fill |
| refill_valid | input | 1 | Fill line present |
| refill_line | input | 256 | Fill line data |

## Verification
The embedded properties watch, on every cycle, the timing of responses against accepted requests, and they check that a plain miss is followed by a refill request carrying the translated page. They also check that the refill address stays steady and that no request is taken while a fill is outstanding, that a fault never starts a fill, and that at most one way matches. Only the bench's scenarios can show that a synonym address hits the line filled through another page number, and that a changed translation misses on a virtual address that hit before. The same holds for word selection inside the line, for the choice of victim after hits and fills in a full set, and for a hit response and the next acceptance overlapping in one cycle.

// File: rtl/vipt_l1.sv
module vipt_l1 #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_BITS  = 13,
  parameter int LINE_BYTES = 32,
  parameter int WAYS       = 2,
  parameter int WORD_W     = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [VA_W-1:0]                req_vaddr,
  output logic                           req_ready,
  output logic                           xlat_req,
  output logic [VA_W-PAGE_BITS-1:0]      xlat_vpn,
  input  logic [PA_W-PAGE_BITS-1:0]      xlat_ppn,
  input  logic                           xlat_fault,
  output logic                           rsp_valid,
  output logic                           rsp_hit,
  output logic                           rsp_miss,
  output logic                           rsp_fault,
  output logic [WORD_W-1:0]              rsp_data,
  output logic                           refill_req,
  output logic [PA_W-1:0]                refill_paddr,
  input  logic                           refill_valid,
  input  logic [LINE_BYTES*8-1:0]        refill_line
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SET_W  = PAGE_BITS - OFF_W;
  localparam int SETS   = 1 << SET_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int PPN_W  = PA_W - PAGE_BITS;
  localparam int WORDS  = LINE_W / WORD_W;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int BOFF_W = $clog2(WORD_W / 8);
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [LINE_W-1:0] data_q [WAYS][SETS];
  logic [PPN_W-1:0]  tag_q  [WAYS][SETS];
  logic [SETS-1:0]   vld_q  [WAYS];
  logic [WAY_W-1:0]  ptr_q  [SETS];

  logic              s1_valid;
  logic [SET_W-1:0]  s1_idx;
  logic [WSEL_W-1:0] s1_wsel;
  logic [LINE_W-1:0] rd_line [WAYS];
  logic [PPN_W-1:0]  rd_tag  [WAYS];
  logic [WAYS-1:0]   rd_vld;

  logic              busy_q;
  logic [PPN_W-1:0]  miss_ppn;
  logic [SET_W-1:0]  miss_idx;

  logic [WAYS-1:0]   hit_vec;
  logic [WAY_W-1:0]  hit_way;
  logic [LINE_W-1:0] hit_line;
  logic [WAY_W-1:0]  victim;
  logic              accept, good, go_refill, refill_fire;
  logic [SET_W-1:0]  req_idx;
  logic              unused_ok;

  function automatic logic [WAY_W-1:0] nxt(input logic [WAY_W-1:0] w);
    return (w == WAY_W'(WAYS - 1)) ? '0 : w + 1'b1;
  endfunction

  assign req_idx     = req_vaddr[PAGE_BITS-1:OFF_W];
  assign unused_ok   = ^req_vaddr[BOFF_W-1:0];
  assign accept      = req_valid && req_ready;
  assign xlat_req    = accept;
  assign xlat_vpn    = req_vaddr[VA_W-1:PAGE_BITS];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = rd_vld[w] && (rd_tag[w] == xlat_ppn);
  end

  always_comb begin
    hit_way  = '0;
    hit_line = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_way  = WAY_W'(w);
        hit_line = rd_line[w];
      end
    end
  end

  always_comb begin
    victim = ptr_q[miss_idx];
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_q[w][miss_idx]) victim = WAY_W'(w);
  end

  assign good        = s1_valid && !xlat_fault;
  assign rsp_valid   = s1_valid;
  assign rsp_hit     = good && (|hit_vec);
  assign rsp_miss    = s1_valid && !rsp_hit;
  assign rsp_fault   = s1_valid && xlat_fault;
  assign rsp_data    = rsp_hit ? hit_line[s1_wsel*WORD_W +: WORD_W] : '0;
  assign go_refill   = good && !(|hit_vec);
  assign req_ready   = !busy_q && !go_refill;
  assign refill_req  = busy_q;
  assign refill_paddr = {miss_ppn, miss_idx, {OFF_W{1'b0}}};
  assign refill_fire = busy_q && refill_valid;

  always_ff @(posedge clk) begin
    if (refill_fire) begin
      data_q[victim][miss_idx] <= refill_line;
      tag_q[victim][miss_idx]  <= miss_ppn;
    end
    if (accept) begin
      for (int w = 0; w < WAYS; w++) begin
        rd_line[w] <= data_q[w][req_idx];
        rd_tag[w]  <= tag_q[w][req_idx];
      end
      s1_idx  <= req_idx;
      s1_wsel <= req_vaddr[OFF_W-1:BOFF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) vld_q[w] <= '0;
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
      rd_vld   <= '0;
      s1_valid <= 1'b0;
      busy_q   <= 1'b0;
      miss_ppn <= '0;
      miss_idx <= '0;
    end else begin
      s1_valid <= accept;
      if (accept)
        for (int w = 0; w < WAYS; w++) rd_vld[w] <= vld_q[w][req_idx];
      if (rsp_hit && hit_way == ptr_q[s1_idx])
        ptr_q[s1_idx] <= nxt(hit_way);
      if (go_refill) begin
        busy_q   <= 1'b1;
        miss_ppn <= xlat_ppn;
        miss_idx <= s1_idx;
      end
      if (refill_fire) begin
        vld_q[victim][miss_idx] <= 1'b1;
        ptr_q[miss_idx]         <= nxt(victim);
        busy_q                  <= 1'b0;
      end
    end
  end

  // R4
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(xlat_req));
  // R6
  miss_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_miss && !rsp_fault) |=> refill_req && refill_paddr[PA_W-1:PAGE_BITS] == $past(xlat_ppn));
  // R6
  refill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && !refill_valid) |=> refill_req && $stable(refill_paddr));
  // R6
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |-> !req_ready && !xlat_req);
  // R9
  fault_no_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault && !refill_req) |=> !refill_req);
  // R7
  onehot_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0(hit_vec));
endmodule

// File: tb/vipt_l1_bench.sv
module vipt_l1_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic req_ready, xlat_req;
  logic [18:0] xlat_vpn;
  logic [18:0] xlat_ppn = '0;
  logic xlat_fault = 1'b0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_data;
  logic refill_req;
  logic [31:0] refill_paddr;
  logic refill_valid = 1'b0;
  logic [255:0] refill_line = '0;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vipt_l1 u_vipt_l1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .xlat_req(xlat_req), .xlat_vpn(xlat_vpn),
    .xlat_ppn(xlat_ppn), .xlat_fault(xlat_fault), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .rsp_data(rsp_data), .refill_req(refill_req), .refill_paddr(refill_paddr),
    .refill_valid(refill_valid), .refill_line(refill_line)
  );

  // {vpn, idx, off, ppn, fault, expected hit}
  localparam logic [52:0] VEC [NVEC] = '{
    {19'd1, 8'h10, 5'h04, 19'h100, 1'b0, 1'b0},
    {19'd1, 8'h10, 5'h04, 19'h100, 1'b0, 1'b1},
    {19'd2, 8'h10, 5'h1C, 19'h100, 1'b0, 1'b1},
    {19'd1, 8'h10, 5'h00, 19'h200, 1'b0, 1'b0},
    {19'd1, 8'h10, 5'h08, 19'h100, 1'b0, 1'b1},
    {19'd3, 8'h10, 5'h14, 19'h300, 1'b0, 1'b0},
    {19'd4, 8'h10, 5'h10, 19'h200, 1'b0, 1'b0},
    {19'd3, 8'h10, 5'h18, 19'h300, 1'b0, 1'b1},
    {19'd5, 8'h10, 5'h00, 19'h100, 1'b1, 1'b0},
    {19'd4, 8'h10, 5'h0C, 19'h200, 1'b0, 1'b1}
  };

  function automatic logic [31:0] word_of(input logic [18:0] ppn, input logic [7:0] idx, input int w);
    return {ppn[11:0], idx, 4'(w), 8'h5A};
  endfunction

  function automatic logic [255:0] line_of(input logic [18:0] ppn, input logic [7:0] idx);
    logic [255:0] l;
    for (int w = 0; w < 8; w++) l[w*32 +: 32] = word_of(ppn, idx, w);
    return l;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [18:0] vpn, input logic [7:0] idx, input logic [4:0] off,
                        input logic [18:0] ppn, input bit flt, input bit exph, input string req);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = {vpn, idx, off};
    #1;
    chk(xlat_req === 1'b1 && xlat_vpn === vpn, "R4 xlat", {xlat_req, xlat_vpn}, {1'b1, vpn});
    @(negedge clk);
    req_valid = 1'b0;
    xlat_ppn = ppn;
    xlat_fault = flt;
    #1;
    chk(rsp_valid === 1'b1, "R4 rsp_valid", rsp_valid, 1);
    chk(rsp_hit === exph, req, rsp_hit, exph);
    chk(rsp_fault === flt && rsp_miss === !exph, "R9 flags", {rsp_fault, rsp_miss}, {flt, !exph});
    if (exph) chk(rsp_data === word_of(ppn, idx, off[4:2]), "R5 data", rsp_data, word_of(ppn, idx, off[4:2]));
    else      chk(rsp_data === 32'h0, "R5 zero data", rsp_data, 0);
    if (!exph && !flt) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = {19'd9, 8'h33, 5'h0};
      #1;
      chk(refill_req === 1'b1 && refill_paddr === {ppn, idx, 5'b0}, "R6 refill addr",
          {refill_req, refill_paddr}, {1'b1, ppn, idx, 5'b0});
      chk(req_ready === 1'b0 && xlat_req === 1'b0, "R6 stall", {req_ready, xlat_req}, 0);
      repeat (2) @(negedge clk);
      #1;
      chk(refill_req === 1'b1 && refill_paddr === {ppn, idx, 5'b0}, "R6 hold", refill_paddr, {ppn, idx, 5'b0});
      req_valid = 1'b0;
      refill_valid = 1'b1;
      refill_line = line_of(ppn, idx);
      @(negedge clk);
      refill_valid = 1'b0;
      #1;
      chk(refill_req === 1'b0 && req_ready === 1'b1, "R7 refill done", {refill_req, req_ready}, 1);
    end else begin
      @(negedge clk);
      #1;
      chk(refill_req === 1'b0 && rsp_valid === 1'b0, "R9 no refill", {refill_req, rsp_valid}, 0);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready === 1'b1 && refill_req === 1'b0 && rsp_valid === 1'b0, "R1 reset",
        {req_ready, refill_req, rsp_valid}, 3'b100);
    rst_n = 1'b1;

    // R1 R2 R3 R7 R8 R9 via the vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [52:0] v;
      v = VEC[i];
      access(v[52:34], v[33:26], v[25:21], v[20:2], v[1], v[0], $sformatf("R3/R8 vec%0d", i));
    end

    // R10: back-to-back hits, set 0x10 holds pages 0x300 and 0x200
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = {19'd7, 8'h10, 5'h00};
    @(negedge clk);
    req_vaddr = {19'd8, 8'h10, 5'h10};
    xlat_ppn = 19'h300;
    xlat_fault = 1'b0;
    #1;
    chk(rsp_hit === 1'b1 && rsp_data === word_of(19'h300, 8'h10, 0), "R10 first hit", rsp_data, word_of(19'h300, 8'h10, 0));
    chk(req_ready === 1'b1 && xlat_req === 1'b1, "R10 overlap accept", {req_ready, xlat_req}, 2'b11);
    @(negedge clk);
    req_valid = 1'b0;
    xlat_ppn = 19'h200;
    #1;
    chk(rsp_hit === 1'b1 && rsp_data === word_of(19'h200, 8'h10, 4), "R10 second hit", rsp_data, word_of(19'h200, 8'h10, 4));

    // R2: other set is independent, same page misses there
    access(19'd3, 8'h22, 5'h08, 19'h300, 1'b0, 1'b0, "R2 other set miss");
    access(19'd6, 8'h22, 5'h08, 19'h300, 1'b0, 1'b1, "R2 other set hit");
    // R8: set 0x10 LRU after back-to-back: 0x200 most recent, so 0x300 is evicted
    access(19'd1, 8'h10, 5'h00, 19'h400, 1'b0, 1'b0, "R8 evict lru");
    access(19'd1, 8'h10, 5'h04, 19'h200, 1'b0, 1'b1, "R8 mru kept");
    access(19'd1, 8'h10, 5'h04, 19'h300, 1'b0, 1'b0, "R8 lru gone");

    @(negedge clk);
    #1;
    chk(rsp_valid === 1'b0, "R4 idle", rsp_valid, 0);
    finish_run();
  end
endmodule